// File: doc/BRIEF.md
# Multichannel 24-bit Audio Serial Port (Stereo / Eight-Slot)

This block is a master-mode audio serial port that both sends and receives. It divides the system clock down to a bit clock, drives a channel/frame clock and a serial output, and samples a serial input. Every channel occupies a 32-bit slot. A slot carries a 24-bit PCM sample, most significant bit first, followed by eight padding bits. Two framings can be selected while running. The stereo framing has two slots in a 64-clock frame, with a left/right clock. The eight-slot framing has a 256-clock frame, marked by a sync pulse one slot wide.

On the parallel side, the block works on 32-bit memory words through valid/ready handshakes. The transmitter takes three words and unpacks them into four 24-bit samples. The receiver packs every four received samples into three words. Bytes are laid out little-endian in both directions. A transmit slot that finds no data sends silence and sets a sticky underrun flag. A received word that cannot be delivered is dropped and sets a sticky overrun flag.

Top module: `pcm_serial_port`

## Requirements
- R1: While `enable` is low, `sck` rests high. While `enable` is high, `sck` toggles every `HALF_DIV` clock cycles, so its period is 2*`HALF_DIV` cycles, and its first transition is a falling edge.
- R2: `sdo` and `lrc` change only on the system clock edge where `sck` falls. `sdi` is sampled on the edge where `sck` rises.
- R3: Each slot is 32 `sck` periods long. Its data starts one `sck` period after the slot boundary: 24 sample bits, MSB first, then 8 padding bits driven as 0.
- R4: With `mode_wide`=0, a frame is 64 bit positions (2 slots). `lrc` is 0 through positions 0 to 31 (left) and 1 through positions 32 to 63 (right).
- R5: With `mode_wide`=1, a frame is 256 bit positions (8 slots, in order 0 to 7). `lrc` is 1 only during positions 0 to 31.
- R6: `mode_wide` is taken only when a new frame begins. A change in the middle of a frame leaves that frame in the old framing.
- R7: The transmit words unpack as follows: s0=w0[23:0], s1={w1[15:0],w0[31:24]}, s2={w2[7:0],w1[31:16]}, s3=w2[31:8]. A word is taken (`tx_valid` and `tx_ready` both high) at the start of each slot that needs one. The fourth sample of a group needs no word.
- R8: If a slot needs a word and `tx_valid` is low, that slot sends 24 zero bits and `tx_underrun` becomes 1. The flag stays set until `enable` is low.
- R9: The receiver keeps the 24 sample bits of each slot and discards the 8 padding bits. It packs samples into `rx_word` with the same layout as R7 and raises `rx_valid` when a word is complete.
- R10: A pending `rx_word` stays stable until `rx_ready` is high. A word that completes while an earlier one is still pending is dropped, and `rx_overrun` becomes 1. The flag stays set until `enable` is low.
- R11: Lowering `enable` resets the bit position, both packing phases and the pending receive word. After `enable` rises again, the first slot starts a new four-sample group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| enable | input | 1 | runs the port; low idles and clears it |
| mode_wide | input | 1 | 0 = stereo framing, 1 = eight-slot framing |
| tx_word | input | 32 | packed transmit word |
| tx_valid | input | 1 | `tx_word` is offered |
| tx_ready | output | 1 | the port takes `tx_word` this cycle |
| rx_word | output | 32 | packed receive word |
| rx_valid | output | 1 | `rx_word` is pending |
| rx_ready | input | 1 | consumer accepts `rx_word` |
| sck | output | 1 | bit clock |
| lrc | output | 1 | channel clock (stereo) or frame sync (eight-slot) |
| sdo | output | 1 | serial data out |
| sdi | input | 1 | serial data in |
| tx_underrun | output | 1 | sticky: a slot found no transmit data |
| rx_overrun | output | 1 | sticky: a received word was dropped |

## Verification
The bench builds the port with `HALF_DIV`=2. This gives a 4-cycle bit clock, so a stereo frame takes 256 cycles and an eight-slot frame takes 1024 cycles. With frames this short, a few thousand cycles cover whole runs in both framings, a mode switch at a frame boundary, running out of transmit words, and a stalled receiver. Serial output is looped back to `sdi`, so every transmitted sample returns through the packer as a word the bench can predict.

// File: rtl/apt_pkg.sv
package apt_pkg;
    localparam int SLOT_W      = 32;
    localparam int SAMPLE_W    = 24;
    localparam int SLOT_LG     = $clog2(SLOT_W);
    localparam int NARROW_SLOTS = 2;
    localparam int WIDE_SLOTS  = 8;
    localparam int POS_W       = $clog2(WIDE_SLOTS * SLOT_W);
    localparam int NARROW_LAST = NARROW_SLOTS * SLOT_W - 1;
    localparam int WIDE_LAST   = WIDE_SLOTS * SLOT_W - 1;

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [SLOT_W-1:0]   word_t;

    // position of a sample inside its four-sample / three-word group
    typedef enum logic [1:0] {PH0, PH1, PH2, PH3} pack_ph_e;
endpackage

// File: rtl/apt_sck_gen.sv
module apt_sck_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic sck,
    output logic fall_tick,
    output logic rise_tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sck;
    } gen_st_t;

    gen_st_t st_d, st_q;
    logic    tick;

    always_comb begin
        st_d      = st_q;
        tick      = en && (st_q.cnt == CW'(HALF_DIV - 1));
        fall_tick = tick && st_q.sck;
        rise_tick = tick && !st_q.sck;
        if (!en) begin
            st_d.cnt = '0;
            st_d.sck = 1'b1;
        end else if (tick) begin
            st_d.cnt = '0;
            st_d.sck = ~st_q.sck;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.sck <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sck = st_q.sck;
endmodule

// File: rtl/apt_tx_unpack.sv
module apt_tx_unpack
    import apt_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    en,
    input  logic    take,
    input  word_t   tx_word,
    input  logic    tx_valid,
    output logic    tx_ready,
    output logic    avail,
    output sample_t sample
);
    typedef struct packed {
        pack_ph_e ph;
        sample_t  res;
    } unp_st_t;

    unp_st_t st_d, st_q;
    sample_t res_nx;

    always_comb begin
        st_d   = st_q;
        sample = '0;
        res_nx = st_q.res;
        unique case (st_q.ph)
            PH0: begin
                sample = tx_word[23:0];
                res_nx = {16'h0, tx_word[31:24]};
            end
            PH1: begin
                sample = {tx_word[15:0], st_q.res[7:0]};
                res_nx = {8'h0, tx_word[31:16]};
            end
            PH2: begin
                sample = {tx_word[7:0], st_q.res[15:0]};
                res_nx = tx_word[31:8];
            end
            PH3: begin
                sample = st_q.res;
                res_nx = '0;
            end
        endcase
        avail    = (st_q.ph == PH3) || tx_valid;
        tx_ready = take && (st_q.ph != PH3);
        if (!en) begin
            st_d.ph  = PH0;
            st_d.res = '0;
        end else if (take && avail) begin
            st_d.ph  = pack_ph_e'(st_q.ph + 2'd1);
            st_d.res = res_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph  <= PH0;
            st_q.res <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/apt_rx_pack.sv
module apt_rx_pack
    import apt_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    en,
    input  logic    push,
    input  sample_t sample,
    input  logic    rx_ready,
    output word_t   rx_word,
    output logic    rx_valid,
    output logic    overrun
);
    typedef struct packed {
        pack_ph_e ph;
        sample_t  res;
        word_t    word;
        logic     valid;
        logic     ovr;
    } pk_st_t;

    pk_st_t  st_d, st_q;
    word_t   built;
    logic    have;
    sample_t res_nx;

    always_comb begin
        st_d   = st_q;
        built  = '0;
        have   = 1'b0;
        res_nx = st_q.res;
        unique case (st_q.ph)
            PH0: res_nx = sample;
            PH1: begin
                built  = {sample[7:0], st_q.res};
                have   = 1'b1;
                res_nx = {8'h0, sample[23:8]};
            end
            PH2: begin
                built  = {sample[15:0], st_q.res[15:0]};
                have   = 1'b1;
                res_nx = {16'h0, sample[23:16]};
            end
            PH3: begin
                built  = {sample, st_q.res[7:0]};
                have   = 1'b1;
                res_nx = '0;
            end
        endcase

        if (st_q.valid && rx_ready) st_d.valid = 1'b0;

        if (!en) begin
            st_d = '0;
        end else if (push) begin
            st_d.ph  = pack_ph_e'(st_q.ph + 2'd1);
            st_d.res = res_nx;
            if (have) begin
                if (st_d.valid) begin
                    st_d.ovr = 1'b1;
                end else begin
                    st_d.word  = built;
                    st_d.valid = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_word  = st_q.word;
    assign rx_valid = st_q.valid;
    assign overrun  = st_q.ovr;
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
    import apt_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        mode_wide,
    input  logic [31:0] tx_word,
    input  logic        tx_valid,
    output logic        tx_ready,
    output logic [31:0] rx_word,
    output logic        rx_valid,
    input  logic        rx_ready,
    output logic        sck,
    output logic        lrc,
    output logic        sdo,
    input  logic        sdi,
    output logic        tx_underrun,
    output logic        rx_overrun
);
    localparam logic [SLOT_LG-1:0] K_LAST = SLOT_LG'(SAMPLE_W - 1);

    typedef struct packed {
        logic [POS_W-1:0]    pos;
        logic                wide;
        logic                sdo;
        logic                lrc;
        sample_t             cur;
        logic [SAMPLE_W-2:0] rxsh;
        logic                under;
    } port_st_t;

    port_st_t st_d, st_q;

    logic               fall_tick, rise_tick;
    logic               take, tx_avail, rx_push, wrap, wide_nx;
    sample_t            tx_sample, src, tx_shift, rx_sample;
    logic [POS_W-1:0]   last, pos_nx;
    logic [SLOT_LG-1:0] k_tx, k_rx;

    apt_sck_gen #(.HALF_DIV(HALF_DIV)) u_sck (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (enable),
        .sck       (sck),
        .fall_tick (fall_tick),
        .rise_tick (rise_tick)
    );

    apt_tx_unpack u_unp (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (enable),
        .take     (take),
        .tx_word  (tx_word),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .avail    (tx_avail),
        .sample   (tx_sample)
    );

    apt_rx_pack u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (enable),
        .push     (rx_push),
        .sample   (rx_sample),
        .rx_ready (rx_ready),
        .rx_word  (rx_word),
        .rx_valid (rx_valid),
        .overrun  (rx_overrun)
    );

    always_comb begin
        st_d    = st_q;
        last    = st_q.wide ? POS_W'(WIDE_LAST) : POS_W'(NARROW_LAST);
        wrap    = (st_q.pos >= last);
        pos_nx  = wrap ? '0 : st_q.pos + 1'b1;
        wide_nx = wrap ? mode_wide : st_q.wide;

        // data trails the slot boundary by one bit clock
        k_tx = pos_nx[SLOT_LG-1:0] - 1'b1;
        take = fall_tick && (k_tx == '0);
        src  = st_q.cur;
        if (take) src = tx_avail ? tx_sample : '0;
        tx_shift = src << k_tx;

        k_rx      = st_q.pos[SLOT_LG-1:0] - 1'b1;
        rx_push   = rise_tick && (k_rx == K_LAST);
        rx_sample = {st_q.rxsh, sdi};

        if (!enable) begin
            st_d      = '0;
            st_d.pos  = '1;
            st_d.wide = mode_wide;
        end else begin
            if (fall_tick) begin
                st_d.pos  = pos_nx;
                st_d.wide = wide_nx;
                st_d.lrc  = wide_nx ? (pos_nx[POS_W-1:SLOT_LG] == '0)
                                    : pos_nx[SLOT_LG];
                st_d.cur  = src;
                st_d.sdo  = (k_tx <= K_LAST) ? tx_shift[SAMPLE_W-1] : 1'b0;
                if (take && !tx_avail) st_d.under = 1'b1;
            end
            if (rise_tick && (k_rx <= K_LAST)) begin
                st_d.rxsh = {st_q.rxsh[SAMPLE_W-3:0], sdi};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.pos <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign lrc         = st_q.lrc;
    assign sdo         = st_q.sdo;
    assign tx_underrun = st_q.under;
endmodule

// File: rtl/apt_checker.sv
module apt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        enable,
    input logic        sck,
    input logic        sdo,
    input logic        lrc,
    input logic        rx_valid,
    input logic        rx_ready,
    input logic [31:0] rx_word,
    input logic        tx_underrun,
    input logic        rx_overrun
);
    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> sck);

    assert_sdo_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(enable) && (sdo != $past(sdo))) |-> $fell(sck));

    assert_lrc_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(enable) && (lrc != $past(lrc))) |-> $fell(sck));

    assert_underrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_underrun && enable) |=> tx_underrun);

    assert_rx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready && enable) |=> (rx_valid && $stable(rx_word)));

    assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overrun && enable) |=> rx_overrun);
endmodule

bind pcm_serial_port apt_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .sck         (sck),
    .sdo         (sdo),
    .lrc         (lrc),
    .rx_valid    (rx_valid),
    .rx_ready    (rx_ready),
    .rx_word     (rx_word),
    .tx_underrun (tx_underrun),
    .rx_overrun  (rx_overrun)
);

// File: tb/sim_pcm_serial_port.sv
module sim_pcm_serial_port;
    localparam int HALF = 2;

    logic        clk = 0, rst_n = 0, enable = 0, mode_wide = 0;
    logic [31:0] tx_word = '0;
    logic        tx_valid = 0, rx_ready = 1;
    logic        tx_ready, rx_valid, sck, lrc, sdo, sdi, tx_underrun, rx_overrun;
    logic [31:0] rx_word;

    always #5 clk = ~clk;
    assign sdi = sdo;

    pcm_serial_port #(.HALF_DIV(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode_wide(mode_wide),
        .tx_word(tx_word), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_word(rx_word), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .sck(sck), .lrc(lrc), .sdo(sdo), .sdi(sdi),
        .tx_underrun(tx_underrun), .rx_overrun(rx_overrun)
    );

    int total = 0, bad = 0;
    logic [23:0] exp_tx[$];
    logic [31:0] exp_rx[$];
    logic [31:0] wq[$];
    bit mon_rx = 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // driver side: four samples become three words (byte little-endian)
    task automatic add_group(input int base);
        logic [23:0] s[4];
        for (int i = 0; i < 4; i++) begin
            s[i] = 24'(((base + i) * 32'h0013_579B) ^ 32'h00A5_C3F1);
            exp_tx.push_back(s[i]);
        end
        wq.push_back({s[1][7:0], s[0]});
        wq.push_back({s[2][15:0], s[1][23:8]});
        wq.push_back({s[3], s[2][23:16]});
        exp_rx.push_back({s[1][7:0], s[0]});
        exp_rx.push_back({s[2][15:0], s[1][23:8]});
        exp_rx.push_back({s[3], s[2][23:16]});
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // transmit word driver
    bit hs = 0;
    always @(negedge clk) begin
        if (hs && wq.size() > 0) void'(wq.pop_front());
        if (enable && wq.size() > 0) begin
            tx_valid = 1'b1;
            tx_word  = wq[0];
        end else begin
            tx_valid = 1'b0;
        end
        hs = tx_valid && tx_ready;
    end

    // serial monitor: decodes sdo/lrc at every rising sck
    int pos_b = 0, frame_b = 64, nrise = 0, since = 0;
    logic [23:0] coll = '0;
    logic prev_sck = 1, prev_sdo = 0, prev_en = 0;
    always @(negedge clk) begin
        since++;
        if (!enable) begin
            pos_b = 0;
            nrise = 0;
            coll  = '0;
        end else begin
            if (prev_en && sdo != prev_sdo)
                chk(prev_sck && !sck, "R2 sdo moved off a falling sck", {31'd0, sck}, 32'd0);
            if (sck && !prev_sck) begin
                int d, k;
                logic e_l;
                logic [23:0] e_s;
                if (nrise == 2) chk(since == 2 * HALF, "R1 sck period", since, 2 * HALF);
                since = 0;
                nrise++;
                if (pos_b == 0) frame_b = mode_wide ? 256 : 64;
                e_l = (frame_b == 256) ? (pos_b < 32) : (pos_b >= 32);
                chk(lrc == e_l, (frame_b == 256) ? "R5 lrc sync" : "R4 lrc channel",
                    {31'd0, lrc}, {31'd0, e_l});
                d = (pos_b + frame_b - 1) % frame_b;
                k = d % 32;
                if (k < 24) coll = {coll[22:0], sdo};
                else chk(sdo == 1'b0, "R3 padding bit", {31'd0, sdo}, 32'd0);
                if (k == 23) begin
                    e_s = (exp_tx.size() > 0) ? exp_tx.pop_front() : 24'd0;
                    chk(coll == e_s, "R3_R7_R8 slot sample", {8'd0, coll}, {8'd0, e_s});
                end
                pos_b++;
                if (pos_b == frame_b) pos_b = 0;
            end
        end
        prev_sck = sck;
        prev_sdo = sdo;
        prev_en  = enable;
    end

    // receive word monitor
    always @(negedge clk) begin
        if (mon_rx && rx_valid && rx_ready) begin
            logic [31:0] e_w;
            e_w = (exp_rx.size() > 0) ? exp_rx.pop_front() : 32'd0;
            chk(rx_word == e_w, "R9 packed rx word", rx_word, e_w);
        end
    end

    task automatic stop_and_clear();
        enable = 0;
        wait_clk(6);
        exp_tx.delete();
        exp_rx.delete();
        wq.delete();
    endtask

    initial begin
        wait_clk(5);
        chk(sck == 1, "R1 reset sck", {31'd0, sck}, 1);
        chk(lrc == 0 && sdo == 0, "R2 reset lrc/sdo", {30'd0, lrc, sdo}, 0);
        chk(!rx_valid && !tx_ready, "R10 reset handshake", {30'd0, rx_valid, tx_ready}, 0);
        chk(!tx_underrun && !rx_overrun, "R8 reset flags", {30'd0, tx_underrun, rx_overrun}, 0);
        rst_n = 1;
        wait_clk(20);
        chk(sck == 1, "R1 idle while disabled", {31'd0, sck}, 1);

        // stereo stream, then running dry
        mode_wide = 0;
        for (int g = 0; g < 3; g++) add_group(g * 4);
        enable = 1;
        wait_clk(1400);
        chk(!tx_underrun, "R8 no underrun while fed", {31'd0, tx_underrun}, 0);
        wait_clk(300);
        chk(tx_underrun, "R8 underrun after words ran out", {31'd0, tx_underrun}, 1);
        wait_clk(400);
        chk(exp_tx.size() == 0, "R7 all stereo samples sent", exp_tx.size(), 0);
        chk(exp_rx.size() == 0, "R9 all stereo words received", exp_rx.size(), 0);
        stop_and_clear();
        chk(!tx_underrun, "R8 underrun cleared by disable", {31'd0, tx_underrun}, 0);

        // eight-slot stream
        mode_wide = 1;
        for (int g = 0; g < 4; g++) add_group(100 + g * 4);
        enable = 1;
        wait_clk(3100);
        chk(exp_tx.size() == 0, "R5 all eight-slot samples sent", exp_tx.size(), 0);
        chk(exp_rx.size() == 0, "R9 all eight-slot words received", exp_rx.size(), 0);
        stop_and_clear();

        // stalled receiver
        mode_wide = 0;
        mon_rx = 0;
        rx_ready = 0;
        for (int g = 0; g < 2; g++) add_group(200 + g * 4);
        enable = 1;
        wait_clk(800);
        chk(rx_valid, "R10 word held pending", {31'd0, rx_valid}, 1);
        chk(rx_word == exp_rx[0], "R10 first word kept", rx_word, exp_rx[0]);
        chk(rx_overrun, "R10 overrun raised", {31'd0, rx_overrun}, 1);
        stop_and_clear();
        chk(!rx_overrun && !rx_valid, "R10_R11 disable clears receive side",
            {30'd0, rx_overrun, rx_valid}, 0);
        rx_ready = 1;
        mon_rx = 1;

        // mode change mid-frame, after a mid-group disable
        mode_wide = 0;
        for (int g = 0; g < 4; g++) add_group(300 + g * 4);
        enable = 1;
        wait_clk(360);
        mode_wide = 1;
        wait_clk(80);
        chk(lrc == 1, "R6 current frame keeps stereo framing", {31'd0, lrc}, 1);
        wait_clk(236);
        chk(lrc == 0, "R6 next frame uses eight-slot framing", {31'd0, lrc}, 0);
        wait_clk(2100);
        chk(exp_tx.size() == 0, "R7_R11 realigned samples all sent", exp_tx.size(), 0);
        chk(exp_rx.size() == 0, "R9_R11 realigned words all received", exp_rx.size(), 0);
        stop_and_clear();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule